// File: doc/BRIEF.md
# Single-Precision Compare, Min/Max and Sign Unit

This unit takes two 32-bit single-precision operands and, on a valid strobe, either compares them, picks the smaller or the larger, or forms the absolute value or the negation of the first one. Before any operand is used it is put into a canonical form. A denormal becomes positive zero. A NaN becomes an infinity that keeps its sign. Negative zero becomes positive zero. Comparisons and flags therefore see only zeros, normal values and infinities.

The result word and a four-bit status register are registered and change on the clock edge that samples the strobe. The zero and negative flags describe the latest operation. The overflow and underflow flags collect events: a NaN operand sets overflow and a denormal operand sets underflow. Both stay set until an explicit status write loads new values. A controller uses the unit to classify a value, to clamp it, or to branch on the outcome of a compare.

Top module: `fcmp_unit`

## Requirements
- R1: While reset is high at a clock edge, the result register and all four flags are cleared to zero.
- R2: Operation codes on `op_sel` are 0 compare, 1 minimum, 2 maximum, 3 absolute value and 4 negate. Codes 5 to 7 and cycles with `in_valid` low leave the result and the flags unchanged, apart from a status write.
- R3: The result and flags of an operation appear at the clock edge that samples `in_valid` high, so each operation takes exactly one cycle.
- R4: Each operand read by an operation is canonicalised. Exponent 0 with a nonzero fraction becomes +0 and sets underflow. Exponent 255 with a nonzero fraction becomes an infinity of the same sign and sets overflow. 0x80000000 becomes +0.
- R5: Compare sets zero when the canonical operands are equal and sets negative when canonical A is less than canonical B. It leaves the result word unchanged.
- R6: Minimum and maximum write the selected canonical operand to the result. When the two are equal, canonical A is written.
- R7: Absolute value writes canonical A with bit 31 cleared. Negate writes canonical A with bit 31 inverted. Only operand A is read, so operand B cannot set overflow or underflow.
- R8: For minimum, maximum, absolute value and negate, zero is set when the result exponent is 0. Negative is set when bit 31 is one and the result is not zero. After any operation, zero and negative are never both set.
- R9: Overflow and underflow are sticky. An operation can only set them.
- R10: A status write (`stat_wr` high) loads the flags from `stat_wdata`, with bit 0 zero, bit 1 negative, bit 2 overflow and bit 3 underflow. It wins over the flag update of an operation in the same cycle, while that operation still updates the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Starts an operation this cycle |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 4 | Status write value {U,V,N,Z} |
| result | output | 32 | Registered result word |
| flag_z | output | 1 | Zero / equal flag |
| flag_n | output | 1 | Negative / less-than flag |
| flag_v | output | 1 | Sticky overflow (NaN seen) flag |
| flag_u | output | 1 | Sticky underflow (denormal seen) flag |

## Verification
The bench builds the unit with the default field widths: an 8-bit exponent and a 23-bit fraction. With these widths the all-zero and all-one exponent codes are reachable directly, so NaNs of both signs, denormals of both signs, infinities and signed zeros can each be applied as literal operands. Opposite-sign and same-negative-sign orderings, equal-operand tie-breaks for minimum and maximum, and negating zero to 0x80000000 are all exercised at these widths.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIGN_B = WORD_W - 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        OP_CMP = 3'd0,
        OP_MIN = 3'd1,
        OP_MAX = 3'd2,
        OP_ABS = 3'd3,
        OP_NEG = 3'd4
    } op_e;

    // Canonical operand plus the events seen while canonicalising it
    typedef struct packed {
        word_t val;
        logic  nan;
        logic  den;
    } opnd_t;

    typedef struct packed {
        logic u;
        logic v;
        logic n;
        logic z;
    } flags_t;

    function automatic logic [EXP_W-1:0] exp_of(input word_t w);
        return w[WORD_W-2 -: EXP_W];
    endfunction

    function automatic logic [FRAC_W-1:0] frac_of(input word_t w);
        return w[FRAC_W-1:0];
    endfunction

    // Monotone unsigned key for canonical values (single zero encoding)
    function automatic word_t order_key(input word_t w);
        if (w[SIGN_B]) return ~w;
        return {1'b1, w[SIGN_B-1:0]};
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  word_t raw,
    output opnd_t canon
);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    logic exp_zero, exp_full, frac_nz;

    always_comb begin
        exp_zero = (exp_of(raw) == '0);
        exp_full = (exp_of(raw) == EXP_MAX);
        frac_nz  = (frac_of(raw) != '0);

        canon.nan = exp_full && frac_nz;
        canon.den = exp_zero && frac_nz;

        if (exp_zero)
            canon.val = '0;
        else if (canon.nan)
            canon.val = {raw[SIGN_B], EXP_MAX, {FRAC_W{1'b0}}};
        else
            canon.val = raw;
    end
endmodule

// File: rtl/fcmp_core.sv
module fcmp_core
    import fcmp_pkg::*;
(
    input  opnd_t      a,
    input  opnd_t      b,
    input  logic [2:0] op_sel,
    output word_t      res,
    output logic       res_wr,
    output flags_t     fl,
    output logic       op_ok
);
    word_t key_a, key_b;
    logic  a_lt, b_lt, eq;
    logic  res_zero;

    always_comb begin
        key_a = order_key(a.val);
        key_b = order_key(b.val);
        a_lt  = key_a < key_b;
        b_lt  = key_b < key_a;
        eq    = key_a == key_b;

        res    = a.val;
        res_wr = 1'b1;
        op_ok  = 1'b1;
        fl.v   = a.nan;
        fl.u   = a.den;

        case (op_sel)
            OP_CMP: begin
                res_wr = 1'b0;
                fl.v   = a.nan | b.nan;
                fl.u   = a.den | b.den;
            end
            OP_MIN: begin
                res  = b_lt ? b.val : a.val;
                fl.v = a.nan | b.nan;
                fl.u = a.den | b.den;
            end
            OP_MAX: begin
                res  = a_lt ? b.val : a.val;
                fl.v = a.nan | b.nan;
                fl.u = a.den | b.den;
            end
            OP_ABS: res = {1'b0, a.val[SIGN_B-1:0]};
            OP_NEG: res = {~a.val[SIGN_B], a.val[SIGN_B-1:0]};
            default: begin
                res_wr = 1'b0;
                op_ok  = 1'b0;
            end
        endcase

        res_zero = (exp_of(res) == '0);
        if (op_sel == OP_CMP) begin
            fl.z = eq;
            fl.n = a_lt;
        end else begin
            fl.z = res_zero;
            fl.n = res[SIGN_B] && !res_zero;
        end
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [2:0]  op_sel,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic        stat_wr,
    input  logic [3:0]  stat_wdata,
    output logic [31:0] result,
    output logic        flag_z,
    output logic        flag_n,
    output logic        flag_v,
    output logic        flag_u
);
    opnd_t  ca, cb;
    word_t  core_res;
    logic   core_wr, core_ok;
    flags_t core_fl;
    word_t  res_q;
    flags_t st_q;

    fcmp_classify u_cls_a (.raw(opnd_a), .canon(ca));
    fcmp_classify u_cls_b (.raw(opnd_b), .canon(cb));

    fcmp_core u_core (
        .a      (ca),
        .b      (cb),
        .op_sel (op_sel),
        .res    (core_res),
        .res_wr (core_wr),
        .fl     (core_fl),
        .op_ok  (core_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            st_q  <= '0;
        end else begin
            if (in_valid && core_wr)
                res_q <= core_res;
            if (stat_wr)
                st_q <= flags_t'(stat_wdata);
            else if (in_valid && core_ok) begin
                st_q.z <= core_fl.z;
                st_q.n <= core_fl.n;
                st_q.v <= st_q.v | core_fl.v;
                st_q.u <= st_q.u | core_fl.u;
            end
        end
    end

    assign result = res_q;
    assign flag_z = st_q.z;
    assign flag_n = st_q.n;
    assign flag_v = st_q.v;
    assign flag_u = st_q.u;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (result == '0 && !flag_z && !flag_n && !flag_v && !flag_u));

    // R5
    a_r5_cmp_holds: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd0) |=> $stable(result));

    // R8
    a_r8_zn_exclusive: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stat_wr && op_sel <= 3'd4) |=> !(flag_z && flag_n));

    // R4
    a_r4_no_special_result: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel >= 3'd1 && op_sel <= 3'd4) |=>
            !(result[30:23] == 8'h00 && result[22:0] != '0) &&
            !(result[30:23] == 8'hFF && result[22:0] != '0));

    // R9
    a_r9_v_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_v && !stat_wr) |=> flag_v);
    a_r9_u_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_u && !stat_wr) |=> flag_u);

    // R10
    a_r10_write_loads: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ({flag_u, flag_v, flag_n, flag_z} == $past(stat_wdata)));

endmodule

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        stat_wr = 1'b0;
    logic [3:0]  stat_wdata = '0;
    logic [31:0] result;
    logic        flag_z, flag_n, flag_v, flag_u;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fcmp_unit u_fcmp_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .result(result),
        .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .flag_u(flag_u)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;   // ignored for compare: result holds
        logic [3:0]  fl;    // {U,V,N,Z}
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 32'h3F800000, 32'h40000000, 32'h0, 4'b0010}, // R5 1<2
        '{3'd0, 32'h40000000, 32'h3F800000, 32'h0, 4'b0000}, // R5 2>1
        '{3'd0, 32'h80000000, 32'h00000000, 32'h0, 4'b0001}, // R4 -0==+0
        '{3'd0, 32'h00000001, 32'h00000000, 32'h0, 4'b1001}, // R4 denorm
        '{3'd0, 32'h7FC00000, 32'h7F800000, 32'h0, 4'b0101}, // R4 NaN=inf
        '{3'd0, 32'hBF800000, 32'h3F800000, 32'h0, 4'b0010}, // R5 -1<1
        '{3'd0, 32'hC0000000, 32'hBF800000, 32'h0, 4'b0010}, // R5 -2<-1
        '{3'd1, 32'h3F800000, 32'hC0000000, 32'hC0000000, 4'b0010}, // R6
        '{3'd2, 32'h3F800000, 32'hC0000000, 32'h3F800000, 4'b0000}, // R6
        '{3'd1, 32'h80000000, 32'h00000000, 32'h00000000, 4'b0001}, // R6 tie
        '{3'd2, 32'hFFC00000, 32'h3F800000, 32'h3F800000, 4'b0100}, // R4
        '{3'd1, 32'hFFC00000, 32'h3F800000, 32'hFF800000, 4'b0110}, // R4
        '{3'd2, 32'h80000001, 32'hBF800000, 32'h00000000, 4'b1001}, // R4
        '{3'd3, 32'hC0400000, 32'hFFFFFFFF, 32'h40400000, 4'b0000}, // R7
        '{3'd4, 32'h40400000, 32'h00000001, 32'hC0400000, 4'b0010}, // R7
        '{3'd4, 32'h00000000, 32'h00000000, 32'h80000000, 4'b0001}, // R8
        '{3'd3, 32'h807FFFFF, 32'h00000000, 32'h00000000, 4'b1001}, // R7
        '{3'd4, 32'h7F800001, 32'h00000000, 32'hFF800000, 4'b0110}, // R7
        '{3'd2, 32'h3F800000, 32'h3F800000, 32'h3F800000, 4'b0000}  // R6
    };

    task automatic check(input string tag, input logic [31:0] exp_res,
                         input logic [3:0] exp_fl);
        logic [3:0] act_fl;
        act_fl = {flag_u, flag_v, flag_n, flag_z};
        checks++;
        if (result !== exp_res || act_fl !== exp_fl) begin
            fails++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     tag, result, act_fl, exp_res, exp_fl);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic v,
                         input logic wr, input logic [3:0] wd);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; in_valid = v;
        stat_wr = wr; stat_wdata = wd;
        @(negedge clk);
        in_valid = 1'b0; stat_wr = 1'b0;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", 32'h0, 4'b0000);

        held = 32'h0;
        for (int i = 0; i < NV; i++) begin
            apply(3'd0, 32'h0, 32'h0, 1'b0, 1'b1, 4'b0000);
            apply(VEC[i].op, VEC[i].a, VEC[i].b, 1'b1, 1'b0, 4'b0000);
            if (VEC[i].op != 3'd0) held = VEC[i].res;
            check($sformatf("R3 R4 R5 R6 R7 R8 vector %0d", i), held, VEC[i].fl);
        end

        // R9: overflow and underflow stay set across a clean operation
        apply(3'd0, 32'h0, 32'h0, 1'b0, 1'b1, 4'b0000);
        apply(3'd0, 32'h7F800001, 32'h00000001, 1'b1, 1'b0, 4'b0000);
        apply(3'd2, 32'h3F800000, 32'h40000000, 1'b1, 1'b0, 4'b0000);
        check("R9 sticky flags", 32'h40000000, 4'b1100);

        // R10: write clears sticky flags
        apply(3'd0, 32'h0, 32'h0, 1'b0, 1'b1, 4'b0011);
        check("R10 status write", 32'h40000000, 4'b0011);

        // R10: write wins over same-cycle flags, result still updates
        apply(3'd4, 32'h7FC00000, 32'h0, 1'b1, 1'b1, 4'b0000);
        check("R10 write priority", 32'hFF800000, 4'b0000);

        // R2: reserved codes ignored
        apply(3'd0, 32'h0, 32'h0, 1'b0, 1'b1, 4'b0101);
        for (int c = 5; c < 8; c++) begin
            apply(3'(c), 32'h00000001, 32'h7FC00000, 1'b1, 1'b0, 4'b0000);
            check($sformatf("R2 reserved code %0d", c), 32'hFF800000, 4'b0101);
        end

        // R2: in_valid low ignored
        apply(3'd3, 32'h00000001, 32'h7FC00000, 1'b0, 1'b0, 4'b0000);
        check("R2 strobe low", 32'hFF800000, 4'b0101);

        // R1: reset clears after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset after use", 32'h0, 4'b0000);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule